// File: doc/BRIEF.md
# Memory Region Access Guard

This block sits beside a memory array and decides, in the same cycle, whether each access may go ahead. Software sets up a parameterized number of regions through a small register port. Each region has a base address, a size counted in 1 KB units, and a control word. The control word holds the read, write and fetch permissions, a secure-only flag, a write-once flag and a lock flag. Each access arrives with its address, its kind, a secure attribute and the word currently stored at that address. The guard then drives a verdict and a write-commit strobe that gates the memory's write enable. A denied write therefore never reaches the array.

The first denied access raises a sticky error event and records its address. Later denials leave that record alone until software clears the event. An interrupt output follows the event when the interrupt enable is set.

Top module: `region_guard`

## Requirements
- R1: A write on the register port with `cfg_idx` below NUM_REGIONS loads that region's base address (`cfg_word`=0) or control word (`cfg_word`=1), and the new value governs accesses from the next cycle on. Control word layout: bit0 read, bit1 write, bit2 fetch, bit3 secure-only, bit4 write-once, bit5 lock, bits [16 +: SIZE_W] size in KB.
- R2: A region matches an address when base <= address < base + size*1024. A region whose size is 0 matches nothing.
- R3: An access that matches no region is allowed.
- R4: When regions overlap, only the lowest-numbered matching region decides.
- R5: Within the deciding region, `acc_kind` 0 (read) and 3 (treated as read) need bit0, 1 (write) needs bit1, and 2 (fetch) needs bit2. A cleared bit denies the access.
- R6: A secure-only region denies every access with `acc_secure`=0, whatever its other bits say.
- R7: In a write-once region, a write is allowed only when `acc_cur` is all ones.
- R8: In a locked region, every write is denied. Reads and fetches still follow their bits.
- R9: `wr_commit` is high exactly when a valid write is allowed. A denied write produces no commit.
- R10: A valid denied access while no error is pending sets `err_event` and loads `err_addr` with its address, both visible in the next cycle.
- R11: While `err_event` is set and not being cleared, it stays set and `err_addr` holds, whatever further denials occur.
- R12: `err_clr` drops `err_event` in the next cycle. If a denial arrives in the same cycle as the clear, the denial wins: the event stays set and the new address is captured.
- R13: A register write with `cfg_idx` = NUM_REGIONS sets the interrupt enable from `cfg_wdata` bit0. `irq` is high exactly when `err_event` and that enable are both set.
- R14: After reset, every region has size 0, `err_event`, `err_addr`, `irq` and the interrupt enable are 0, and so every access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register port write strobe |
| cfg_idx | input | IDX_W | Region index, or NUM_REGIONS for the interrupt control |
| cfg_word | input | 1 | 0 selects base address, 1 selects control word |
| cfg_wdata | input | ADDR_W | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| acc_secure | input | 1 | Access is secure |
| acc_cur | input | DATA_W | Word currently stored at the address |
| err_clr | input | 1 | Clears the error event |
| acc_allow | output | 1 | Verdict for the presented access |
| acc_hit | output | 1 | Some region matched the address |
| wr_commit | output | 1 | Write enable for the memory array |
| err_event | output | 1 | Sticky access-error event |
| err_addr | output | ADDR_W | Address of the first recorded denial |
| irq | output | 1 | Interrupt request |

## Verification
Clearing the error event and a fresh denial can land in the same cycle. In that case the capture logic has to choose between dropping the event and recording the new address. The bench provokes this directly with a denied access presented together with `err_clr`. It also raises `err_clr` at random alongside random denials. A bench model applies the rule that the denial wins and the new address replaces the old one. The bench then compares `err_event`, `err_addr` and `irq` against that model one cycle later.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  // control word field positions (decoded by every region slot)
  localparam int CW_RD     = 0;
  localparam int CW_WR     = 1;
  localparam int CW_EX     = 2;
  localparam int CW_SEC    = 3;
  localparam int CW_WONCE  = 4;
  localparam int CW_LOCK   = 5;
  localparam int CW_SIZE   = 16;
  localparam int KB_SHIFT  = 10;
endpackage

// File: rtl/guard_slot.sv
module guard_slot
  import guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_base,
  input  logic              we_ctrl,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ADDR_W-1:0] addr,
  input  acc_kind_e         kind,
  input  logic              secure,
  input  logic [DATA_W-1:0] cur,
  output logic              hit,
  output logic              ok
);
  typedef logic [ADDR_W:0] wide_t;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ctrl_q;
  logic [SIZE_W-1:0] size_kb;

  assign size_kb = ctrl_q[CW_SIZE +: SIZE_W];

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [SIZE_W-1:0] kb);
    wide_t span;
    wide_t off;
    span = wide_t'(kb) << KB_SHIFT;
    off  = wide_t'(a - b);
    return (kb != '0) && (a >= b) && (off < span);
  endfunction

  function automatic logic permits(input logic [ADDR_W-1:0] cw,
                                   input acc_kind_e k,
                                   input logic sec,
                                   input logic [DATA_W-1:0] word);
    logic kind_ok;
    case (k)
      KIND_WRITE: kind_ok = cw[CW_WR] && !cw[CW_LOCK] && (!cw[CW_WONCE] || (&word));
      KIND_FETCH: kind_ok = cw[CW_EX];
      default:    kind_ok = cw[CW_RD];
    endcase
    return kind_ok && (!cw[CW_SEC] || sec);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_base) base_q <= wdata;
      if (we_ctrl) ctrl_q <= wdata;
    end
  end

  assign hit = in_window(addr, base_q, size_kb);
  assign ok  = permits(ctrl_q, kind, secure, cur);

  // R2: an empty region never claims an address
  assert_empty_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_kb == '0) |-> !hit);
  // R8: a locked region never approves a write
  assert_lock_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CW_LOCK] && kind == KIND_WRITE) |-> !ok);
  // R7: write-once approval implies an erased word
  assert_wonce_erased_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CW_WONCE] && kind == KIND_WRITE && ok) |-> (&cur));
  // R6: non-secure traffic never approved by a secure-only region
  assert_secure_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CW_SEC] && !secure) |-> !ok);
endmodule

// File: rtl/guard_err_latch.sv
module guard_err_latch #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deny_evt,
  input  logic [ADDR_W-1:0] deny_addr,
  input  logic              clr,
  input  logic              irq_en,
  output logic              err_event,
  output logic [ADDR_W-1:0] err_addr,
  output logic              irq
);
  logic err_q;
  logic capture;

  // a denial takes the slot when it is free or being freed this cycle
  assign capture = deny_evt && (!err_q || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      err_addr <= '0;
    end else if (capture) begin
      err_q    <= 1'b1;
      err_addr <= deny_addr;
    end else if (clr) begin
      err_q    <= 1'b0;
    end
  end

  assign err_event = err_q;
  assign irq       = err_q && irq_en;

  assert_event_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_event && !clr) |=> err_event);
  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_event && !clr) |=> $stable(err_addr));
  assert_first_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_evt && !err_event) |=> (err_event && err_addr == $past(deny_addr)));
  assert_clear_race_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_evt && clr) |=> (err_event && err_addr == $past(deny_addr)));
  assert_clear_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !deny_evt) |=> !err_event);
  assert_irq_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_event);
endmodule

// File: rtl/region_guard.sv
module region_guard
  import guard_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SIZE_W      = 10,
  localparam int IDX_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_word,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_secure,
  input  logic [DATA_W-1:0] acc_cur,
  input  logic              err_clr,
  output logic              acc_allow,
  output logic              acc_hit,
  output logic              wr_commit,
  output logic              err_event,
  output logic [ADDR_W-1:0] err_addr,
  output logic              irq
);
  acc_kind_e              kind;
  logic [NUM_REGIONS-1:0] hit_vec;
  logic [NUM_REGIONS-1:0] ok_vec;
  logic                   sel_ok;
  logic                   deny_evt;
  logic                   irq_en_q;
  logic                   ctl_we;

  assign kind   = acc_kind_e'(acc_kind);
  assign ctl_we = cfg_we && (cfg_idx == IDX_W'(NUM_REGIONS));

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    logic sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(i));
    guard_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_base (sel && !cfg_word),
      .we_ctrl (sel && cfg_word),
      .wdata   (cfg_wdata),
      .addr    (acc_addr),
      .kind    (kind),
      .secure  (acc_secure),
      .cur     (acc_cur),
      .hit     (hit_vec[i]),
      .ok      (ok_vec[i])
    );
  end

  // walk downward so the lowest matching index is the last to assign
  always_comb begin
    sel_ok = 1'b1;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_ok = ok_vec[i];
    end
  end

  assign acc_hit   = |hit_vec;
  assign acc_allow = sel_ok;
  assign wr_commit = acc_valid && (kind == KIND_WRITE) && acc_allow;
  assign deny_evt  = acc_valid && !acc_allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_en_q <= 1'b0;
    else if (ctl_we) irq_en_q <= cfg_wdata[0];
  end

  guard_err_latch #(.ADDR_W(ADDR_W)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .deny_evt  (deny_evt),
    .deny_addr (acc_addr),
    .clr       (err_clr),
    .irq_en    (irq_en_q),
    .err_event (err_event),
    .err_addr  (err_addr),
    .irq       (irq)
  );

  assert_unmatched_allow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> acc_allow);
  assert_lowest_decides_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (acc_allow == ok_vec[0]));
  assert_commit_only_allowed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (acc_valid && acc_allow && kind == KIND_WRITE));
  assert_no_commit_on_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |-> !wr_commit);
endmodule

// File: tb/sim_region_guard.sv
`timescale 1ns/1ps
module sim_region_guard;
  localparam int NR = 4;
  localparam int IW = $clog2(NR + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_word = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          acc_valid = 1'b0;
  logic [31:0]   acc_addr = '0;
  logic [1:0]    acc_kind = '0;
  logic          acc_secure = 1'b0;
  logic [31:0]   acc_cur = '0;
  logic          err_clr = 1'b0;
  logic          acc_allow, acc_hit, wr_commit, err_event, irq;
  logic [31:0]   err_addr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_base [NR];
  logic [31:0] m_ctrl [NR];
  bit          m_irqen, m_err;
  logic [31:0] m_addr;

  always #2.5 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_secure(acc_secure), .acc_cur(acc_cur), .err_clr(err_clr), .acc_allow(acc_allow),
    .acc_hit(acc_hit), .wr_commit(wr_commit), .err_event(err_event), .err_addr(err_addr),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit rule_ok(input logic [31:0] cw, input logic [1:0] k,
                                 input bit sec, input logic [31:0] cur);
    bit r;
    if (cw[3] && !sec) return 0;
    if (k == 2'd1)      r = cw[1] && !cw[5] && (!cw[4] || cur == 32'hFFFF_FFFF);
    else if (k == 2'd2) r = cw[2];
    else                r = cw[0];
    return r;
  endfunction

  function automatic bit exp_allow(input logic [31:0] a, input logic [1:0] k,
                                   input bit sec, input logic [31:0] cur);
    bit verdict = 1;
    for (int i = NR - 1; i >= 0; i--) begin
      longint lo = longint'(m_base[i]);
      longint sz = longint'(m_ctrl[i][25:16]) * 1024;
      if (sz != 0 && longint'(a) >= lo && longint'(a) < lo + sz)
        verdict = rule_ok(m_ctrl[i], k, sec, cur);
    end
    return verdict;
  endfunction

  task automatic cfg_write(input int idx, input bit word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_word = word; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == NR) m_irqen = d[0];
    else if (word) m_ctrl[idx] = d;
    else m_base[idx] = d;
  endtask

  task automatic region(input int idx, input logic [31:0] b, input int kb, input logic [5:0] bits);
    cfg_write(idx, 1'b0, b);
    cfg_write(idx, 1'b1, (32'(kb) << 16) | 32'(bits));
  endtask

  task automatic access(input string req, input bit v, input logic [31:0] a, input logic [1:0] k,
                        input bit sec, input logic [31:0] cur, input bit clr);
    bit e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_kind = k; acc_secure = sec; acc_cur = cur; err_clr = clr;
    #1;
    e = exp_allow(a, k, sec, cur);
    chk({req, " verdict"}, 32'(acc_allow), 32'(e));
    chk({req, " R9 commit"}, 32'(wr_commit), 32'(v && k == 2'd1 && e));
    if (v && !e && (!m_err || clr)) begin
      m_err = 1; m_addr = a;
    end else if (clr) m_err = 0;
    @(posedge clk);
    #1;
    acc_valid = 1'b0; err_clr = 1'b0;
    chk({req, " R10/R11 event"}, 32'(err_event), 32'(m_err));
    chk({req, " R10/R11 addr"}, err_addr, m_addr);
    chk({req, " R13 irq"}, 32'(irq), 32'(m_err && m_irqen));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_ctrl[i] = '0; end
    m_irqen = 0; m_err = 0; m_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R14 reset state
    chk("R14 event", 32'(err_event), 0);
    chk("R14 addr", err_addr, 0);
    chk("R14 irq", 32'(irq), 0);
    access("R14 R3 no region", 1, 32'h1234, 2'd1, 0, 32'h0, 0);

    // R1 R2 R4: region0 read-only 0x1000..0x1FFF, region1 RWX 0x1800..0x37FF
    region(0, 32'h1000, 4, 6'b000001);
    region(1, 32'h1800, 8, 6'b000111);
    access("R3 below R2", 1, 32'h0FFF, 2'd1, 0, 32'h0, 0);
    access("R5 R2 read low edge", 1, 32'h1000, 2'd0, 0, 32'h0, 0);
    access("R4 overlap write", 1, 32'h1900, 2'd1, 0, 32'h0, 0);
    access("R11 second deny", 1, 32'h1FFC, 2'd1, 0, 32'h0, 0);
    access("R2 R4 beyond r0", 1, 32'h2000, 2'd1, 0, 32'h0, 0);
    access("R5 fetch r1", 1, 32'h3000, 2'd2, 0, 32'h0, 0);
    access("R5 kind3 read", 1, 32'h1004, 2'd3, 0, 32'h0, 0);
    access("R2 top edge", 1, 32'h3800, 2'd2, 0, 32'h0, 0);
    access("R12 clear", 0, 32'h0, 2'd0, 0, 32'h0, 1);

    // R13 interrupt enable, R6 secure-only
    cfg_write(NR, 1'b0, 32'h1);
    region(2, 32'h8000, 1, 6'b001111);
    access("R6 nonsecure", 1, 32'h8004, 2'd0, 0, 32'h0, 0);
    access("R6 secure", 1, 32'h8008, 2'd0, 1, 32'h0, 0);
    access("R12 clear with deny", 1, 32'h8010, 2'd2, 0, 32'h0, 1);
    access("R12 clear", 0, 32'h0, 2'd0, 0, 32'h0, 1);

    // R7 write-once, R8 lock
    region(3, 32'hA000, 2, 6'b010011);
    access("R7 erased", 1, 32'hA000, 2'd1, 0, 32'hFFFF_FFFF, 0);
    access("R7 programmed", 1, 32'hA004, 2'd1, 0, 32'hFFFF_FFFE, 0);
    access("R12 clear", 0, 32'h0, 2'd0, 0, 32'h0, 1);
    region(3, 32'hA000, 2, 6'b100111);
    access("R8 locked write", 1, 32'hA100, 2'd1, 1, 32'hFFFF_FFFF, 0);
    access("R8 locked read", 1, 32'hA100, 2'd0, 1, 32'h0, 0);
    access("R8 locked fetch", 1, 32'hA104, 2'd2, 1, 32'h0, 0);
    cfg_write(NR, 1'b0, 32'h0);
    access("R13 irq off", 1, 32'hA108, 2'd1, 0, 32'h0, 0);

    // constrained random mix
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < NR; i++)
        region(i, $urandom_range(0, 32'h7F) << 8, $urandom_range(0, 8), 6'($urandom));
      cfg_write(NR, 1'b0, 32'($urandom_range(0, 1)));
      for (int n = 0; n < 120; n++) begin
        access("R4 R5 R6 R7 R8 R12 random", $urandom_range(0, 7) != 0,
               $urandom_range(0, 32'hBFFF) & 32'hFFFF_FFFC, 2'($urandom),
               1'($urandom), ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom,
               $urandom_range(0, 7) == 0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule